// File: doc/BRIEF.md
# Integer ALU with Status Flags

This block is the arithmetic stage of a small 32-bit integer datapath. Each cycle it receives two operands, which arrive already formed (any immediate has been zero-extended upstream), and a three-bit operation code. It produces a result on a combinational path. Alongside the result it keeps a four-bit status register holding the negative, zero, carry and overflow conditions of the last operation that was allowed to update them.

Eight operations are supported:

- Five write a result: add, add with carry, subtract, subtract with carry, and negate.
- Three only probe values: compare (subtract), compare-negative (add) and test (bitwise AND). They discard their value and raise no result strobe, but they still update the status bits, so that a later conditional step can act on them.

Subtraction is done as an addition of the inverted operand plus one. For this reason the carry bit means "no borrow" after any subtract-type operation.

Top module: `flag_alu`

## Requirements
- R1: An active-low asynchronous reset clears the status register to zero. `flags_o` packs the bits as N in bit 3, Z in bit 2, C in bit 1 and V in bit 0.
- R2: The operation codes that write a result are:
  - 0 add: A+B
  - 1 add with carry: A+B+C
  - 2 subtract: A−B
  - 3 subtract with carry: A−B−(1−C)
  - 4 negate: 0−B

  All of them are computed modulo 2^32, and `res_o` shows the value in the same cycle.
- R3: Codes 5 (compare, A−B), 6 (compare-negative, A+B) and 7 (test, A&B) hold `res_valid_o` low and drive `res_o` to zero. Codes 0 to 4 hold `res_valid_o` high.
- R4: The status register changes only on a rising clock edge at which `flag_we_i` is high. With `flag_we_i` low, every bit keeps its value whatever the operation.
- R5: On an update, N takes bit 31 of the computed value and Z is set when that value is zero. For codes 5 to 7 the computed value is the discarded one.
- R6: For add-type codes (0, 1, 6), C is the carry out of bit 31, so 0x80000000 + 0x80000000 sets C.
- R7: For subtract-type codes (2, 3, 4, 5), C is the carry out of A + ~B + carry-in, meaning C is set when no borrow occurs. Thus 0x10 − 0x01 sets C and 1 − 2 clears it.
- R8: For all arithmetic codes, V is set when the signed result has a sign that the operands' signs cannot produce. So 0x7FFFFFFF + 1 sets V with C clear, and negating 0x80000000 sets V.
- R9: The test operation (code 7) updates only N and Z. C and V keep their previous values.
- R10: Add with carry and subtract with carry use the C bit held in the register during the cycle they execute. They do not see the carry that the same operation writes at the end of that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Operation code (see R2, R3) |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand (zero-extended immediate or register) |
| flag_we_i | input | 1 | Allows the status register to update at the next edge |
| res_o | output | 32 | Result of a writing operation, zero otherwise |
| res_valid_o | output | 1 | High when the current operation writes a result |
| flags_o | output | 4 | Registered status bits {N, Z, C, V} |

## Verification
Two things meet in the same cycle for the carry-consuming operations. The stored carry is read to form the result, and the carry that operation produces is written back at the closing edge. The bench provokes this in three ways:

- It presets C through a compare.
- It issues add with carry twice back to back with the flag update enabled, so that the first operation clears the carry the second one would otherwise see.
- It checks each result before its edge.

The second result must show the cleared carry, not the preset one. The vector table sets C both ways before every carry-sensitive entry. This covers the case where a subtract-with-carry sees C=0 and C=1 and must yield values that differ by one.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_ADC = 3'd1,
    OP_SUB = 3'd2,
    OP_SBC = 3'd3,
    OP_NEG = 3'd4,
    OP_CMP = 3'd5,
    OP_CMN = 3'd6,
    OP_TST = 3'd7
  } alu_op_e;

  localparam int FLAG_N = 3;
  localparam int FLAG_Z = 2;
  localparam int FLAG_C = 1;
  localparam int FLAG_V = 0;

  // true when the operation delivers a value downstream
  function automatic logic op_writes(alu_op_e op);
    return (op != OP_CMP) && (op != OP_CMN) && (op != OP_TST);
  endfunction

  // true when the value comes from the bitwise path instead of the adder
  function automatic logic op_is_logic(alu_op_e op);
    return op == OP_TST;
  endfunction

endpackage

// File: rtl/alu_operand_prep.sv
module alu_operand_prep
  import flag_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              c_flag,
  output logic [DATA_W-1:0] opa,
  output logic [DATA_W-1:0] opb,
  output logic              cin
);

  always_comb begin
    opa = a;
    opb = b;
    cin = 1'b0;
    unique case (op)
      OP_ADC: cin = c_flag;
      OP_SUB,
      OP_CMP: begin
        opb = ~b;
        cin = 1'b1;
      end
      OP_SBC: begin
        opb = ~b;
        cin = c_flag;
      end
      OP_NEG: begin
        opa = '0;
        opb = ~b;
        cin = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic              cin,
  output logic [DATA_W-1:0] sum,
  output logic              cout,
  output logic              ovf
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W:0] wide;

  always_comb begin
    wide = {1'b0, opa} + {1'b0, opb} + {{DATA_W{1'b0}}, cin};
    sum  = wide[MSB:0];
    cout = wide[DATA_W];
    ovf  = (opa[MSB] == opb[MSB]) && (sum[MSB] != opa[MSB]);
  end

endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
  import flag_alu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic       upd_cv,
  input  logic [1:0] nz_new,
  input  logic [1:0] cv_new,
  output logic [3:0] flags
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= 4'b0000;
    end else if (we) begin
      flags[FLAG_N] <= nz_new[1];
      flags[FLAG_Z] <= nz_new[0];
      if (upd_cv) begin
        flags[FLAG_C] <= cv_new[1];
        flags[FLAG_V] <= cv_new[0];
      end
    end
  end

endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import flag_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              flag_we_i,
  output logic [DATA_W-1:0] res_o,
  output logic              res_valid_o,
  output logic [3:0]        flags_o
);

  localparam int MSB = DATA_W - 1;

  alu_op_e           op;
  logic [DATA_W-1:0] opa, opb, add_sum, logic_value, ex_value;
  logic              cin, add_cout, add_ovf;
  logic              writes, use_logic, c_now;

  assign op        = alu_op_e'(op_i);
  assign c_now     = flags_o[FLAG_C];
  assign writes    = op_writes(op);
  assign use_logic = op_is_logic(op);

  alu_operand_prep #(.DATA_W(DATA_W)) u_prep (
    .op     (op),
    .a      (a_i),
    .b      (b_i),
    .c_flag (c_now),
    .opa    (opa),
    .opb    (opb),
    .cin    (cin)
  );

  alu_addsub #(.DATA_W(DATA_W)) u_add (
    .opa  (opa),
    .opb  (opb),
    .cin  (cin),
    .sum  (add_sum),
    .cout (add_cout),
    .ovf  (add_ovf)
  );

  assign logic_value = a_i & b_i;
  assign ex_value    = use_logic ? logic_value : add_sum;

  assign res_o       = writes ? ex_value : '0;
  assign res_valid_o = writes;

  alu_flag_reg u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (flag_we_i),
    .upd_cv (!use_logic),
    .nz_new ({ex_value[MSB], ex_value == '0}),
    .cv_new ({add_cout, add_ovf}),
    .flags  (flags_o)
  );

endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk
  import flag_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        op_i,
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] b_i,
  input logic              flag_we_i,
  input logic [DATA_W-1:0] res_o,
  input logic              res_valid_o,
  input logic [3:0]        flags_o,
  input logic [DATA_W-1:0] ex_value
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W:0] plain_sum;
  assign plain_sum = {1'b0, a_i} + {1'b0, b_i};

  // R3: a non-writing operation leaves the result bus at zero
  p_quiet_result_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid_o |-> res_o == '0);

  // R4: no enable, no change
  p_hold_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_we_i |=> $stable(flags_o));

  // R5: N and Z follow the computed value
  p_nz_track_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we_i |=> (flags_o[FLAG_N] == $past(ex_value[MSB])) &&
                  (flags_o[FLAG_Z] == ($past(ex_value) == '0)));

  // R6: carry on plain add is bit DATA_W of an unbounded sum
  p_add_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we_i && op_i == OP_ADD |=> flags_o[FLAG_C] == $past(plain_sum[DATA_W]));

  // R7: carry on subtract means A was not below B
  p_sub_noborrow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we_i && op_i == OP_SUB |=> flags_o[FLAG_C] == $past(a_i >= b_i));

  // R8: signed overflow on plain add
  p_add_ovf_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we_i && op_i == OP_ADD |=>
      flags_o[FLAG_V] == $past((a_i[MSB] == b_i[MSB]) && (plain_sum[MSB] != a_i[MSB])));

  // R9: test keeps C and V
  p_test_keeps_cv_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we_i && op_i == OP_TST |=> flags_o[1:0] == $past(flags_o[1:0]));

endmodule

bind flag_alu flag_alu_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .op_i        (op_i),
  .a_i         (a_i),
  .b_i         (b_i),
  .flag_we_i   (flag_we_i),
  .res_o       (res_o),
  .res_valid_o (res_valid_o),
  .flags_o     (flags_o),
  .ex_value    (ex_value)
);

// File: tb/tb_flag_alu.sv
module tb_flag_alu;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op_i = 3'd0;
  logic [31:0] a_i = '0, b_i = '0;
  logic        flag_we_i = 1'b0;
  logic [31:0] res_o;
  logic        res_valid_o;
  logic [3:0]  flags_o;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  flag_alu dut (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .a_i(a_i), .b_i(b_i),
    .flag_we_i(flag_we_i), .res_o(res_o), .res_valid_o(res_valid_o),
    .flags_o(flags_o)
  );

  typedef struct packed {
    logic [2:0]  op;
    logic [31:0] a;
    logic [31:0] b;
    logic        cin;
    logic [31:0] res;
    logic [3:0]  fl;
  } vec_t;

  // res is the expected res_o (zero for codes 5..7); fl is {N,Z,C,V}
  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{3'd0, 32'h80000000, 32'h80000000, 1'b0, 32'h00000000, 4'b0111}, // R6 R8
    '{3'd0, 32'h7FFFFFFF, 32'h00000001, 1'b0, 32'h80000000, 4'b1001}, // R8
    '{3'd0, 32'h00000005, 32'h00000007, 1'b0, 32'h0000000C, 4'b0000}, // R2
    '{3'd1, 32'hFFFFFFFF, 32'h00000000, 1'b1, 32'h00000000, 4'b0110}, // R2 R6
    '{3'd1, 32'h00000001, 32'h00000002, 1'b0, 32'h00000003, 4'b0000}, // R2
    '{3'd2, 32'h00000010, 32'h00000001, 1'b0, 32'h0000000F, 4'b0010}, // R7
    '{3'd2, 32'h00000001, 32'h00000002, 1'b0, 32'hFFFFFFFF, 4'b1000}, // R7
    '{3'd2, 32'h80000000, 32'h00000001, 1'b0, 32'h7FFFFFFF, 4'b0011}, // R8
    '{3'd3, 32'h00000005, 32'h00000003, 1'b0, 32'h00000001, 4'b0010}, // R2 R7
    '{3'd3, 32'h00000005, 32'h00000003, 1'b1, 32'h00000002, 4'b0010}, // R2
    '{3'd4, 32'h12345678, 32'h00000001, 1'b0, 32'hFFFFFFFF, 4'b1000}, // R2 R7
    '{3'd4, 32'h00000000, 32'h00000000, 1'b0, 32'h00000000, 4'b0110}, // R7
    '{3'd4, 32'h00000000, 32'h80000000, 1'b0, 32'h80000000, 4'b1001}, // R8
    '{3'd5, 32'h00000007, 32'h00000007, 1'b0, 32'h00000000, 4'b0110}, // R3 R5
    '{3'd5, 32'h00000003, 32'h00000005, 1'b1, 32'h00000000, 4'b1000}, // R3 R7
    '{3'd6, 32'hFFFFFFFF, 32'h00000001, 1'b0, 32'h00000000, 4'b0110}, // R3 R6
    '{3'd7, 32'h000000F0, 32'h0000000F, 1'b0, 32'h00000000, 4'b0100}, // R3 R9
    '{3'd7, 32'h80000000, 32'hFFFFFFFF, 1'b1, 32'h00000000, 4'b1010}  // R5 R9
  };

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // drive at the falling edge, check the combinational result, then the flags
  task automatic step(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                      input logic we);
    @(negedge clk);
    op_i = op; a_i = a; b_i = b; flag_we_i = we;
    #1;
  endtask

  task automatic after_edge();
    @(posedge clk);
    #1;
  endtask

  // presets C: compare 0,0 leaves 0110, add 0,0 leaves 0100
  task automatic preset_c(input logic c);
    step(c ? 3'd5 : 3'd0, 32'h0, 32'h0, 1'b1);
    after_edge();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got hung expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (2) @(posedge clk);
    #1;
    check("R1 reset flags", {28'h0, flags_o}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // table walk
    for (int i = 0; i < NV; i++) begin
      preset_c(VEC[i].cin);
      step(VEC[i].op, VEC[i].a, VEC[i].b, 1'b1);
      check($sformatf("R2/R3 result vec%0d", i), res_o, VEC[i].res);
      check($sformatf("R3 valid vec%0d", i), {31'h0, res_valid_o},
            {31'h0, (VEC[i].op < 3'd5)});
      after_edge();
      check($sformatf("R5-R9 flags vec%0d", i), {28'h0, flags_o}, {28'h0, VEC[i].fl});
    end

    // R9: V set before a test must survive it
    step(3'd0, 32'h7FFFFFFF, 32'h1, 1'b1);
    after_edge();
    step(3'd7, 32'h1, 32'h1, 1'b1);
    after_edge();
    check("R9 test keeps V", {28'h0, flags_o}, 32'h1);

    // R4: disabled update leaves flags (0001) untouched
    step(3'd0, 32'h80000000, 32'h80000000, 1'b0);
    check("R4 result still computed", res_o, 32'h0);
    after_edge();
    check("R4 flags held", {28'h0, flags_o}, 32'h1);

    // R10: back-to-back carry consumption
    preset_c(1'b1);
    step(3'd1, 32'h1, 32'h1, 1'b1);
    check("R10 first adc uses C=1", res_o, 32'h3);
    after_edge();
    check("R10 first adc clears C", {28'h0, flags_o}, 32'h0);
    step(3'd1, 32'h1, 32'h1, 1'b1);
    check("R10 second adc sees C=0", res_o, 32'h2);
    after_edge();

    // R10 with subtract-with-carry: C written by the same op is not used
    preset_c(1'b0);
    step(3'd3, 32'h5, 32'h5, 1'b1);
    check("R10 sbc uses C=0", res_o, 32'hFFFFFFFF);
    after_edge();
    check("R7 sbc borrow flags", {28'h0, flags_o}, 32'h8);

    // R1: asynchronous reset mid-run
    step(3'd5, 32'h0, 32'h0, 1'b1);
    after_edge();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 async clear", {28'h0, flags_o}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule